// File: doc/BRIEF.md
# Paged Indirect Register Access Sequencer

This block sits on the master side of a management bus. It turns one wide register request into a series of 16-bit management transactions, all aimed at one fixed pseudo-PHY address. A request names a page, a register offset within that page, a direction and a data width of 8, 16, 32, 48 or 64 bits. The sequencer selects the page, moves the data through four 16-bit data windows, writes a command word and then polls the command register until the target reports that the access has finished.

The sequencer remembers the last page it selected and skips the page-select write when the next request uses the same page. An invalidate input, and reset, set the remembered page to 0xFF, which forces a page write on the next access to any other page. The completion poll is bounded: after a fixed number of busy answers the request ends with an error. Any failed management transaction also stops the sequence at once.

The management side is an abstract parallel port. Each transaction carries a PHY address, a register number, a direction and write data, and it is held until the bus acknowledges it. Serial bit framing belongs to a separate block.

Top module: `paged_reg_seq`

## Requirements
- R1: Every management transaction uses PHY address 0x1E and one of these register numbers: 0x10 (page select), 0x11 (command and status), or 0x18, 0x19, 0x1A, 0x1B (data windows holding words 0 to 3). The port asserts no transaction while busy_o is low.
- R2: The page-select write carries {page, 8'h01}. It is issued only when the requested page differs from the cached page. The cache holds 0xFF after reset and after an inval_i pulse, so a first request for page 0xFF skips the page write.
- R3: A write sends every data word before the command word. Word k goes to register 0x18+k, starting with the least significant 16 bits. The word count comes from width_i: 0 is 8 bits (1 word, upper byte sent as zero), 1 is 16 bits (1 word), 2 is 32 bits (2 words), 3 is 48 bits (3 words), and 4 to 7 are 64 bits (4 words).
- R4: The command word goes to register 0x11 as {offset, 6'b0, read, write}: bit 0 is set for a write and bit 1 is set for a read.
- R5: After the command, register 0x11 is read until its bits 1:0 are both clear. Between one poll read that returns busy and the next poll read, the port stays idle for exactly POLL_WAIT cycles (default 10).
- R6: If the fifth poll read still returns busy, the request ends with err_o and no further transaction is issued.
- R7: After a read completes, words 0x18+k are read in ascending order and placed in rdata_o[16k+15:16k]. An 8-bit read keeps only bits 7:0 of word 0. Bits above the requested width read as zero.
- R8: A transaction acknowledged with mg_err_i ends the request at once with err_o and no further transaction. A failed page write leaves the page cache unchanged.
- R9: busy_o rises on the cycle after a request is accepted and falls in the same cycle that the one-cycle done_o or err_o pulse appears. done_o and err_o never occur together. req_i is ignored while busy.
- R10: While a management request waits for mg_ack_i, mg_req_o stays high and its direction, register number and write data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a request (accepted when idle) |
| wr_i | input | 1 | 1 = write, 0 = read |
| width_i | input | 3 | Access width code (see R3) |
| page_i | input | 8 | Register page |
| offset_i | input | 8 | Register offset within the page |
| wdata_i | input | 64 | Write data, least significant word first |
| inval_i | input | 1 | Invalidate the page cache (set it to 0xFF) |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle pulse: request completed |
| err_o | output | 1 | One-cycle pulse: request failed or timed out |
| rdata_o | output | 64 | Assembled read data |
| mg_req_o | output | 1 | Management transaction request |
| mg_wr_o | output | 1 | Management transaction is a write |
| mg_phy_o | output | 5 | Management PHY address |
| mg_reg_o | output | 5 | Management register number |
| mg_wdata_o | output | 16 | Management write data |
| mg_rdata_i | input | 16 | Management read data (valid with ack) |
| mg_ack_i | input | 1 | Management transaction accepted |
| mg_err_i | input | 1 | Management transaction failed (with ack) |

## Verification
The visible symptoms of a wrong page cache depend on the direction of the error. A stale cache entry leaves out the page write, so the data lands in the wrong page, which shows up in the read data returned on the next read request. A cache that does not update adds page writes that show up in the transaction log of the next request. A bad word index or word count shows up within the same request: a data window is written or read out of order, or rdata_o comes back with misplaced words. A wrong poll counter or wait counter shows up in the same request, either as a poll count other than five before the error or as a gap between poll reads other than POLL_WAIT. The bench therefore compares the whole transaction sequence of every request, including the idle gaps between poll reads.

// File: rtl/prs_pkg.sv
package prs_pkg;
  localparam logic [4:0] REG_PAGE  = 5'h10;
  localparam logic [4:0] REG_CMD   = 5'h11;
  localparam logic [4:0] REG_DATA0 = 5'h18;

  typedef enum logic [2:0] {
    W_8 = 3'd0, W_16 = 3'd1, W_32 = 3'd2, W_48 = 3'd3, W_64 = 3'd4
  } width_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PAGE, ST_WDATA, ST_CMD, ST_POLL, ST_WAIT, ST_RDATA
  } state_e;

  function automatic logic [2:0] words_of(input logic [2:0] w);
    case (w)
      W_8, W_16: words_of = 3'd1;
      W_32:      words_of = 3'd2;
      W_48:      words_of = 3'd3;
      default:   words_of = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/prs_page_cache.sv
module prs_page_cache #(
  parameter int          PW       = 8,
  parameter logic [PW-1:0] INVALID = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inval_i,
  input  logic          upd_i,
  input  logic [PW-1:0] upd_page_i,
  input  logic [PW-1:0] cmp_page_i,
  output logic          miss_o
);
  logic [PW-1:0] page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      page_q <= INVALID;
    else if (inval_i) page_q <= INVALID;
    else if (upd_i)   page_q <= upd_page_i;
  end

  assign miss_o = (cmp_page_i != page_q);
endmodule

// File: rtl/prs_wait_timer.sv
module prs_wait_timer #(
  parameter int WAIT = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expire_o
);
  localparam int CW = (WAIT < 2) ? 1 : $clog2(WAIT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= CW'(WAIT);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // last cycle of the wait window
  assign expire_o = (cnt_q == CW'(1));
endmodule

// File: rtl/prs_rd_assembler.sv
module prs_rd_assembler #(
  parameter int LANES = 4,
  parameter int LW    = 16,
  localparam int IW   = (LANES < 2) ? 1 : $clog2(LANES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               we_i,
  input  logic [IW-1:0]      idx_i,
  input  logic               byte_only_i,
  input  logic [LW-1:0]      word_i,
  output logic [LANES*LW-1:0] data_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       lane_q <= '0;
      else if (clear_i)  lane_q <= '0;
      else if (we_i && idx_i == IW'(g)) begin
        if (g == 0 && byte_only_i) lane_q <= {{(LW-8){1'b0}}, word_i[7:0]};
        else                       lane_q <= word_i;
      end
    end
    assign data_o[g*LW +: LW] = lane_q;
  end
endmodule

// File: rtl/paged_reg_seq.sv
module paged_reg_seq
  import prs_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR   = 5'h1E,
  parameter int         POLL_TRIES = 5,
  parameter int         POLL_WAIT  = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        wr_i,
  input  logic [2:0]  width_i,
  input  logic [7:0]  page_i,
  input  logic [7:0]  offset_i,
  input  logic [63:0] wdata_i,
  input  logic        inval_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  output logic [63:0] rdata_o,
  output logic        mg_req_o,
  output logic        mg_wr_o,
  output logic [4:0]  mg_phy_o,
  output logic [4:0]  mg_reg_o,
  output logic [15:0] mg_wdata_o,
  input  logic [15:0] mg_rdata_i,
  input  logic        mg_ack_i,
  input  logic        mg_err_i
);
  localparam int TW = $clog2(POLL_TRIES + 1);

  state_e        state_q;
  logic [7:0]    page_q, off_q;
  logic          wr_q, byte_q;
  logic [2:0]    nw_q;
  logic [63:0]   wdata_q;
  logic [1:0]    idx_q;
  logic [TW-1:0] tries_q;
  logic          done_q, err_q;

  logic xfer, fail, ok, last_word, poll_clear, accept, page_miss, tmr_load, tmr_exp;

  assign accept     = (state_q == ST_IDLE) && req_i;
  assign xfer       = mg_req_o && mg_ack_i;
  assign fail       = xfer && mg_err_i;
  assign ok         = xfer && !mg_err_i;
  assign last_word  = ({1'b0, idx_q} == nw_q - 3'd1);
  assign poll_clear = (mg_rdata_i[1:0] == 2'b00);
  assign tmr_load   = ok && (state_q == ST_POLL) && !poll_clear &&
                      (tries_q != TW'(POLL_TRIES - 1));

  prs_page_cache #(.PW(8)) u_cache (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inval_i    (inval_i),
    .upd_i      (ok && state_q == ST_PAGE),
    .upd_page_i (page_q),
    .cmp_page_i (page_i),
    .miss_o     (page_miss)
  );

  prs_wait_timer #(.WAIT(POLL_WAIT)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .expire_o (tmr_exp)
  );

  prs_rd_assembler #(.LANES(4), .LW(16)) u_asm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (accept && !wr_i),
    .we_i        (ok && state_q == ST_RDATA),
    .idx_i       (idx_q),
    .byte_only_i (byte_q),
    .word_i      (mg_rdata_i),
    .data_o      (rdata_o)
  );

  always_comb begin
    mg_req_o   = 1'b0;
    mg_wr_o    = 1'b0;
    mg_reg_o   = '0;
    mg_wdata_o = '0;
    case (state_q)
      ST_PAGE: begin
        mg_req_o = 1'b1; mg_wr_o = 1'b1; mg_reg_o = REG_PAGE;
        mg_wdata_o = {page_q, 8'h01};
      end
      ST_WDATA: begin
        mg_req_o = 1'b1; mg_wr_o = 1'b1;
        mg_reg_o = REG_DATA0 + 5'(idx_q);
        mg_wdata_o = wdata_q[{idx_q, 4'b0} +: 16];
      end
      ST_CMD: begin
        mg_req_o = 1'b1; mg_wr_o = 1'b1; mg_reg_o = REG_CMD;
        mg_wdata_o = {off_q, 6'b0, ~wr_q, wr_q};
      end
      ST_POLL: begin
        mg_req_o = 1'b1; mg_reg_o = REG_CMD;
      end
      ST_RDATA: begin
        mg_req_o = 1'b1; mg_reg_o = REG_DATA0 + 5'(idx_q);
      end
      default: ;
    endcase
  end

  assign mg_phy_o = PHY_ADDR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      off_q   <= '0;
      wr_q    <= 1'b0;
      byte_q  <= 1'b0;
      nw_q    <= 3'd1;
      wdata_q <= '0;
      idx_q   <= '0;
      tries_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (req_i) begin
          page_q  <= page_i;
          off_q   <= offset_i;
          wr_q    <= wr_i;
          byte_q  <= (width_i == W_8);
          nw_q    <= words_of(width_i);
          wdata_q <= (width_i == W_8) ? {56'b0, wdata_i[7:0]} : wdata_i;
          idx_q   <= '0;
          tries_q <= '0;
          if (page_miss)  state_q <= ST_PAGE;
          else if (wr_i)  state_q <= ST_WDATA;
          else            state_q <= ST_CMD;
        end
      end else if (state_q == ST_WAIT) begin
        if (tmr_exp) state_q <= ST_POLL;
      end else if (fail) begin
        state_q <= ST_IDLE;
        err_q   <= 1'b1;
      end else if (ok) begin
        case (state_q)
          ST_PAGE: state_q <= wr_q ? ST_WDATA : ST_CMD;
          ST_WDATA: begin
            if (last_word) begin
              state_q <= ST_CMD;
              idx_q   <= '0;
            end else idx_q <= idx_q + 2'd1;
          end
          ST_CMD: state_q <= ST_POLL;
          ST_POLL: begin
            if (poll_clear) begin
              if (wr_q) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end else begin
                state_q <= ST_RDATA;
                idx_q   <= '0;
              end
            end else if (tries_q == TW'(POLL_TRIES - 1)) begin
              state_q <= ST_IDLE;
              err_q   <= 1'b1;
            end else begin
              tries_q <= tries_q + 1'b1;
              state_q <= ST_WAIT;
            end
          end
          ST_RDATA: begin
            if (last_word) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else idx_q <= idx_q + 2'd1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/prs_chk.sv
module prs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic        mg_req_o,
  input logic        mg_wr_o,
  input logic [4:0]  mg_reg_o,
  input logic [15:0] mg_wdata_o,
  input logic        mg_ack_i
);
  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mg_req_o && !mg_ack_i |=> mg_req_o && $stable(mg_wr_o) &&
                              $stable(mg_reg_o) && $stable(mg_wdata_o));

  // R9
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  // R9
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o || err_o));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |=> !(done_o || err_o));

  // R1
  legal_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mg_req_o |-> busy_o && (mg_reg_o == 5'h10 || mg_reg_o == 5'h11 ||
                            mg_reg_o[4:2] == 3'b110));
endmodule

bind paged_reg_seq prs_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .mg_req_o   (mg_req_o),
  .mg_wr_o    (mg_wr_o),
  .mg_reg_o   (mg_reg_o),
  .mg_wdata_o (mg_wdata_o),
  .mg_ack_i   (mg_ack_i)
);

// File: tb/paged_reg_seq_tb.sv
module paged_reg_seq_tb;
  localparam int PW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req = 0, wr = 0, inval = 0;
  logic [2:0]  width = 0;
  logic [7:0]  page = 0, off = 0;
  logic [63:0] wdata = 0;
  logic        busy, done, err;
  logic [63:0] rdata;
  logic        mg_req, mg_wr;
  logic [4:0]  mg_phy, mg_reg;
  logic [15:0] mg_wdata;
  logic [15:0] mg_rdata = 0;
  logic        mg_ack = 0, mg_err = 0;

  paged_reg_seq #(.POLL_WAIT(PW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .width_i(width),
    .page_i(page), .offset_i(off), .wdata_i(wdata), .inval_i(inval),
    .busy_o(busy), .done_o(done), .err_o(err), .rdata_o(rdata),
    .mg_req_o(mg_req), .mg_wr_o(mg_wr), .mg_phy_o(mg_phy), .mg_reg_o(mg_reg),
    .mg_wdata_o(mg_wdata), .mg_rdata_i(mg_rdata), .mg_ack_i(mg_ack),
    .mg_err_i(mg_err));

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit c, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // slave model and transaction log
  int n_tr, busy_plan, busy_left, err_idx, lat, idle_cnt;
  logic [7:0]  s_page;
  logic [15:0] s_cmd;
  logic        lg_wr  [64];
  logic [4:0]  lg_reg [64];
  logic [4:0]  lg_phy [64];
  logic [15:0] lg_dat [64];
  int          lg_gap [64];

  function automatic logic [15:0] vword(input logic [7:0] p, input logic [7:0] r, input int k);
    return {p ^ 8'h5A, r + 8'(k * 37)} ^ 16'(k * 16'h1111);
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mg_ack = 0; mg_err = 0; s_page = 8'hFF; s_cmd = 0; busy_left = 0; lat = 0;
    end else if (mg_ack) begin
      mg_ack = 0; mg_err = 0;
      if (!mg_req) idle_cnt++;
    end else if (!mg_req) begin
      idle_cnt++;
    end else if (lat > 0) begin
      lat--;
    end else begin
      if (n_tr < 64) begin
        lg_wr[n_tr] = mg_wr; lg_reg[n_tr] = mg_reg; lg_phy[n_tr] = mg_phy;
        lg_dat[n_tr] = mg_wdata; lg_gap[n_tr] = idle_cnt;
      end
      mg_ack = 1;
      mg_rdata = 16'(n_tr * 16'h0F0F);
      if (n_tr == err_idx) mg_err = 1;
      else if (mg_wr) begin
        if (mg_reg == 5'h10) s_page = mg_wdata[15:8];
        else if (mg_reg == 5'h11) begin s_cmd = mg_wdata; busy_left = busy_plan; end
      end else begin
        if (mg_reg == 5'h11) begin
          if (busy_left > 0) begin
            mg_rdata = {s_cmd[15:8], 6'b0, s_cmd[1:0]}; busy_left--;
          end else mg_rdata = {s_cmd[15:8], 8'h00};
        end else if (mg_reg[4:2] == 3'b110) mg_rdata = vword(s_page, s_cmd[15:8], int'(mg_reg[1:0]));
      end
      n_tr++; idle_cnt = 0; lat = $urandom % 3;
    end
  end

  // bench expectation state
  logic [7:0] exp_cache = 8'hFF;
  logic       e_wr  [32];
  logic [4:0] e_reg [32];
  logic [15:0] e_dat [32];
  int         e_gap [32];
  int         e_n;

  function automatic int nwords(input logic [2:0] w);
    return (w <= 3'd1) ? 1 : (w == 3'd2) ? 2 : (w == 3'd3) ? 3 : 4;
  endfunction

  task automatic add(input logic w, input logic [4:0] r, input logic [15:0] d, input int g);
    e_wr[e_n] = w; e_reg[e_n] = r; e_dat[e_n] = d; e_gap[e_n] = g; e_n++;
  endtask

  task automatic run_op(input logic w, input logic [7:0] p, input logic [7:0] o,
                        input logic [2:0] wd, input logic [63:0] d, input int bp, input int ei);
    int nw, np, seq_bad, first_bad;
    bit timeout, has_page, exp_err, got_done, got_err;
    logic [63:0] exp_rd, wd8;
    nw = nwords(wd);
    e_n = 0;
    has_page = (p != exp_cache);
    wd8 = (wd == 3'd0) ? {56'b0, d[7:0]} : d;
    if (has_page) add(1, 5'h10, {p, 8'h01}, -1);
    if (w) for (int k = 0; k < nw; k++) add(1, 5'(8'h18 + k), wd8[k*16 +: 16], -1);
    add(1, 5'h11, {o, 6'b0, ~w, w}, -1);
    timeout = (bp >= 5);
    np = timeout ? 5 : bp + 1;
    for (int j = 0; j < np; j++) add(0, 5'h11, 16'h0, (j > 0) ? PW : -1);
    if (!timeout && !w) for (int k = 0; k < nw; k++) add(0, 5'(8'h18 + k), 16'h0, -1);
    exp_err = timeout;
    if (ei < e_n) begin e_n = ei + 1; exp_err = 1; end
    if (has_page && ei != 0) exp_cache = p;
    exp_rd = 0;
    for (int k = 0; k < nw; k++) exp_rd[k*16 +: 16] = vword(p, o, k);
    if (wd == 3'd0) exp_rd = {56'b0, exp_rd[7:0]};

    busy_plan = bp; err_idx = ei; n_tr = 0; idle_cnt = 0;
    req = 1; wr = w; page = p; off = o; width = wd; wdata = d;
    @(negedge clk);
    check(busy == 1'b1, "R9 busy after accept", busy, 1);
    // garbage while busy must be ignored (R9)
    wr = ~w; page = ~p; off = ~o; width = 3'd2; wdata = ~d;
    @(negedge clk);
    req = 0;
    while (!(done || err)) @(negedge clk);
    got_done = done; got_err = err;
    check(busy == 1'b0, "R9 busy low at pulse", busy, 0);
    check(got_err == exp_err && got_done == !exp_err,
          "R6 R8 outcome", {got_done, got_err}, {!exp_err, exp_err});
    check(n_tr == e_n, "R2 R3 R6 R8 transaction count", n_tr, e_n);
    seq_bad = 0; first_bad = -1;
    for (int i = 0; i < e_n && i < n_tr; i++) begin
      if (lg_wr[i] != e_wr[i] || lg_reg[i] != e_reg[i] || lg_phy[i] != 5'h1E ||
          (e_wr[i] && lg_dat[i] != e_dat[i]) || (e_gap[i] >= 0 && lg_gap[i] != e_gap[i])) begin
        seq_bad++;
        if (first_bad < 0) first_bad = i;
      end
    end
    if (first_bad >= 0)
      check(0, "R1 R2 R3 R4 R5 sequence", {lg_wr[first_bad], lg_reg[first_bad], lg_dat[first_bad], 8'(lg_gap[first_bad])},
            {e_wr[first_bad], e_reg[first_bad], e_dat[first_bad], 8'(e_gap[first_bad])});
    else check(1, "R1 sequence", 0, 0);
    if (!w && !exp_err) check(rdata == exp_rd, "R7 read data", rdata, exp_rd);
    @(negedge clk);
  endtask

  bit finished = 0;
  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    err_idx = 99; busy_plan = 0; n_tr = 0; idle_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    check(!busy && !done && !err && !mg_req, "R9 reset state", {busy, done, err, mg_req}, 0);
    // R2 page 0xFF after reset: no page write
    run_op(0, 8'hFF, 8'h04, 3'd1, 0, 0, 99);
    run_op(1, 8'h03, 8'h10, 3'd4, 64'h1122_3344_5566_7788, 0, 99);   // R3 64-bit write
    run_op(0, 8'h03, 8'h22, 3'd0, 0, 1, 99);                         // R7 8-bit read, cache hit
    run_op(1, 8'h03, 8'h23, 3'd0, 64'hFFFF_FFFF_FFFF_ABCD, 0, 99);   // R3 8-bit write
    run_op(0, 8'h03, 8'h30, 3'd3, 0, 2, 99);                         // R7 48-bit read
    run_op(0, 8'h04, 8'h31, 3'd2, 0, 4, 99);                         // R5 five polls, last clear
    run_op(0, 8'h04, 8'h32, 3'd4, 0, 5, 99);                         // R6 timeout
    run_op(1, 8'h09, 8'h40, 3'd2, 64'hDEAD_BEEF, 0, 0);              // R8 page write fails
    run_op(1, 8'h09, 8'h40, 3'd2, 64'hDEAD_BEEF, 0, 99);             // R8 page rewritten
    run_op(1, 8'h0A, 8'h41, 3'd4, 64'h0123_4567_89AB_CDEF, 0, 2);    // R8 data write fails
    // R2 invalidate forces page write on a repeated page
    inval = 1; @(negedge clk); inval = 0; exp_cache = 8'hFF;
    run_op(0, 8'h0A, 8'h42, 3'd1, 0, 0, 99);
    for (int n = 0; n < 150; n++) begin
      logic [7:0] p;
      int bp, ei;
      p = ($urandom % 4 == 0) ? exp_cache : 8'($urandom % 6);
      bp = ($urandom % 6 == 0) ? 5 : int'($urandom % 4);
      ei = ($urandom % 8 == 0) ? int'($urandom % 9) : 99;
      if ($urandom % 20 == 0) begin
        inval = 1; @(negedge clk); inval = 0; exp_cache = 8'hFF;
      end
      run_op(1'($urandom), p, 8'($urandom), 3'($urandom % 8),
             {$urandom, $urandom}, bp, ei);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule